// File: doc/BRIEF.md
# Fixed-Frame MMIO Request Bridge

This block turns fixed-size request frames, delivered one byte at a time on a valid/ready stream, into memory-mapped accesses on a 32-bit Wishbone master port. It serves an external processor model that sits behind a byte-stream link. Each 32-byte request holds a read, a write or an interrupt poll. The bridge decodes the request and runs the bus cycles it needs. It then sends back a 32-byte response on a second byte stream, carrying the result and a snapshot of a 32-bit interrupt vector.

The bridge works in strict lock-step. While a request is decoded, executed and answered, the request stream is held off. The next frame is accepted only after the last response byte has been taken. Frames that are malformed never reach the bus. A bus slave that never acknowledges is abandoned after a fixed number of clocks, so the link can never hang on a dead address.

Top module: `mmio_frame_bridge`

## Requirements
- R1: Byte i of a frame occupies bits [8i+7:8i] of that frame, so every multi-byte field is little-endian. A request is exactly 32 accepted bytes, and each request gets exactly one 32-byte response.
- R2: Response header layout: bytes 0-3 hold 0x3052584C, bytes 4-5 hold 1, bytes 6-7 echo the request op, bytes 8-11 echo the request size, bytes 12-15 hold the interrupt vector sampled when the response is formed, and bytes 16-23 are zero.
- R3: Op 0 (read) runs bus read cycles. The requested bytes are returned zero-extended in response bytes 24-31.
- R4: Op 1 (write) runs bus write cycles with the we line high, carrying data from request bytes 24-31. A write response carries zero in its data field.
- R5: Lane mapping on the 32-bit bus. The bus address is the request address with bits [1:0] cleared. Size 1 sets select bit addr[1:0]. Size 2 sets select bits {addr[1],0} and {addr[1],1}. Size 4 sets all four select bits. Write data is shifted into the selected lanes, and read data is taken from them.
- R6: Size 8 runs two back-to-back 32-bit cycles. The first goes to the aligned address and carries the low word; the second goes to the aligned address plus 4 and carries the high word.
- R7: Op 2 (interrupt poll) with size 0 runs no bus cycle. It returns zero data and the current interrupt vector.
- R8: A request is malformed if any of these holds: request bytes 0-3 are not 0x3051584C; version is not 1; op is above 2; a read or write has a size other than 1, 2, 4 or 8; a poll has a size other than 0; bytes 12-15 are not zero; or the address does not fit the bus address width. A malformed request runs no bus cycle and is answered with all-ones data.
- R9: A bus cycle that has not been acknowledged after 256 clocks of strobe is dropped. The response data field is then all ones.
- R10: Request ready stays low from the last request byte until the last response byte is accepted.
- R11: After reset: request ready is high, response valid is low and the bus cycle line is low.
- R12: While response valid is high and response ready is low, the response byte holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_data | input | 8 | Request stream byte |
| req_valid | input | 1 | Request byte valid |
| req_ready | output | 1 | Bridge can take a request byte |
| rsp_data | output | 8 | Response stream byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Consumer takes the response byte |
| irq_vec | input | 32 | Interrupt bitmask reported in responses |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | ADDR_W | Word-aligned byte address |
| wb_dat_w | output | 32 | Write data |
| wb_sel | output | 4 | Byte lane selects |
| wb_dat_r | input | 32 | Read data |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
The response path and the request path meet when a consumer stalls a finished response while the producer already offers the next frame. The bench holds response ready low for a stretch with request valid high. Each stalled cycle it requires request ready to stay low and the response byte to stay fixed, then drains the response and confirms the waiting frame is executed afterwards. A second overlap, an unacknowledged strobe running into the timeout limit, is judged by the exact count of strobe cycles, the all-ones result, and a normal read completing right after.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

    localparam int unsigned FRAME_BYTES = 32;
    localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8;

    localparam logic [31:0] REQ_MAGIC = 32'h3051_584C;
    localparam logic [31:0] RSP_MAGIC = 32'h3052_584C;
    localparam logic [15:0] FRAME_VER = 16'd1;

    localparam logic [15:0] OP_READ = 16'd0;
    localparam logic [15:0] OP_WRITE = 16'd1;
    localparam logic [15:0] OP_POLL  = 16'd2;

    typedef struct packed {
        logic [63:0] payload;
        logic [63:0] addr;
        logic [31:0] rsvd;
        logic [31:0] size;
        logic [15:0] op;
        logic [15:0] version;
        logic [31:0] magic;
    } req_frame_t;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_DECODE,
        ST_BUS,
        ST_REPLY
    } bridge_state_e;

    function automatic req_frame_t unpack_req(input logic [FRAME_BITS-1:0] f);
        return req_frame_t'(f);
    endfunction

    function automatic logic [FRAME_BITS-1:0] pack_rsp(
        input logic [15:0] op,
        input logic [31:0] size,
        input logic [31:0] irq,
        input logic [63:0] data
    );
        return {data, 64'h0, irq, size, op, FRAME_VER, RSP_MAGIC};
    endfunction

    function automatic logic size_is_access(input logic [31:0] size);
        return (size == 32'd1) || (size == 32'd2) || (size == 32'd4) || (size == 32'd8);
    endfunction

    // Byte offset within the 32-bit word that an access starts at.
    function automatic logic [1:0] lane_offset(input logic [31:0] size, input logic [1:0] a);
        case (size)
            32'd1:   return a;
            32'd2:   return {a[1], 1'b0};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [31:0] size, input logic [1:0] a);
        case (size)
            32'd1:   return 4'b0001 << lane_offset(size, a);
            32'd2:   return 4'b0011 << lane_offset(size, a);
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [63:0] place_write(input logic [31:0] size, input logic [1:0] a,
                                                input logic [63:0] d);
        logic [4:0] sh;
        sh = {lane_offset(size, a), 3'b000};
        case (size)
            32'd1:   return {32'h0, 24'h0, d[7:0]} << sh;
            32'd2:   return {32'h0, 16'h0, d[15:0]} << sh;
            32'd4:   return {32'h0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] extract_read(input logic [31:0] size, input logic [1:0] a,
                                                 input logic [63:0] d);
        logic [31:0] w;
        w = d[31:0] >> {lane_offset(size, a), 3'b000};
        case (size)
            32'd1:   return {56'h0, w[7:0]};
            32'd2:   return {48'h0, w[15:0]};
            32'd4:   return {32'h0, w};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/mfb_rx_deser.sv
module mfb_rx_deser
    import mfb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    output logic                  last_beat,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int unsigned CNT_W = $clog2(FRAME_BYTES);

    logic [CNT_W-1:0] count;
    logic             take;

    assign take      = enable && in_valid;
    assign last_beat = take && (count == CNT_W'(FRAME_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            frame <= '0;
        end else if (take) begin
            frame <= {in_data, frame[FRAME_BITS-1:8]};
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/mfb_tx_ser.sv
module mfb_tx_ser
    import mfb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_frame,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [7:0]            out_data,
    output logic                  last_beat
);
    localparam int unsigned CNT_W = $clog2(FRAME_BYTES);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      count;
    logic                  give;

    assign out_data  = shreg[7:0];
    assign give      = out_valid && out_ready;
    assign last_beat = give && (count == CNT_W'(FRAME_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            count     <= '0;
            out_valid <= 1'b0;
        end else if (load) begin
            shreg     <= load_frame;
            count     <= '0;
            out_valid <= 1'b1;
        end else if (give) begin
            shreg <= {8'h00, shreg[FRAME_BITS-1:8]};
            count <= count + 1'b1;
            if (last_beat) out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/mfb_bus_engine.sv
module mfb_bus_engine #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              write,
    input  logic              two_words,
    input  logic [ADDR_W-1:0] base_adr,
    input  logic [3:0]        sel,
    input  logic [63:0]       wdata,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [31:0]       wb_dat_w,
    output logic [3:0]        wb_sel,
    input  logic [31:0]       wb_dat_r,
    input  logic              wb_ack,
    output logic              done,
    output logic              timed_out,
    output logic [63:0]       rdata
);
    localparam int unsigned TMO_W = $clog2(TIMEOUT + 1);

    typedef enum logic { ENG_IDLE, ENG_ACTIVE } eng_state_e;

    eng_state_e        st;
    logic              hi_word;
    logic              pair;
    logic              we_r;
    logic [ADDR_W-1:0] adr_r;
    logic [3:0]        sel_r;
    logic [63:0]       wdata_r;
    logic [TMO_W-1:0]  wait_cnt;

    assign wb_cyc   = (st == ENG_ACTIVE);
    assign wb_stb   = (st == ENG_ACTIVE);
    assign wb_we    = we_r;
    assign wb_sel   = sel_r;
    assign wb_adr   = hi_word ? adr_r + ADDR_W'(4) : adr_r;
    assign wb_dat_w = hi_word ? wdata_r[63:32] : wdata_r[31:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ENG_IDLE;
            hi_word   <= 1'b0;
            pair      <= 1'b0;
            we_r      <= 1'b0;
            adr_r     <= '0;
            sel_r     <= '0;
            wdata_r   <= '0;
            wait_cnt  <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
            rdata     <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    if (start) begin
                        st        <= ENG_ACTIVE;
                        hi_word   <= 1'b0;
                        pair      <= two_words;
                        we_r      <= write;
                        adr_r     <= base_adr;
                        sel_r     <= sel;
                        wdata_r   <= wdata;
                        wait_cnt  <= '0;
                        timed_out <= 1'b0;
                        rdata     <= '0;
                    end
                end
                ENG_ACTIVE: begin
                    if (wb_ack) begin
                        wait_cnt <= '0;
                        if (hi_word) rdata[63:32] <= wb_dat_r;
                        else         rdata[31:0]  <= wb_dat_r;
                        if (pair && !hi_word) begin
                            hi_word <= 1'b1;
                        end else begin
                            st   <= ENG_IDLE;
                            done <= 1'b1;
                        end
                    end else if (wait_cnt == TMO_W'(TIMEOUT - 1)) begin
                        st        <= ENG_IDLE;
                        done      <= 1'b1;
                        timed_out <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mmio_frame_bridge.sv
module mmio_frame_bridge
    import mfb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        req_data,
    input  logic              req_valid,
    output logic              req_ready,
    output logic [7:0]        rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    input  logic [31:0]       irq_vec,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [31:0]       wb_dat_w,
    output logic [3:0]        wb_sel,
    input  logic [31:0]       wb_dat_r,
    input  logic              wb_ack
);
    bridge_state_e         st, st_nxt;
    logic [FRAME_BITS-1:0] rx_frame;
    logic                  rx_last;
    logic                  tx_last;
    req_frame_t            req;
    logic                  well_formed;
    logic                  is_poll;
    logic                  addr_fits;
    logic                  rsp_load;
    logic [63:0]           rsp_payload;
    logic                  eng_start;
    logic                  eng_done;
    logic                  eng_tmo;
    logic [63:0]           eng_rdata;

    assign req_ready = (st == ST_COLLECT);

    mfb_rx_deser u_rx (
        .clk       (clk),
        .rst       (rst),
        .enable    (req_ready),
        .in_valid  (req_valid),
        .in_data   (req_data),
        .last_beat (rx_last),
        .frame     (rx_frame)
    );

    // Decoding is combinational on the held frame; it stays valid until the
    // next collection phase because the deserializer is idle meanwhile.
    assign req     = unpack_req(rx_frame);
    assign is_poll = (req.op == OP_POLL);

    generate
        if (ADDR_W < 64) begin : g_addr_chk
            assign addr_fits = (req.addr[63:ADDR_W] == '0);
        end else begin : g_addr_full
            assign addr_fits = 1'b1;
        end
    endgenerate

    always_comb begin
        well_formed = (req.magic == REQ_MAGIC) && (req.version == FRAME_VER)
                   && (req.rsvd == 32'h0) && addr_fits;
        if (req.op == OP_READ || req.op == OP_WRITE)
            well_formed = well_formed && size_is_access(req.size);
        else if (is_poll)
            well_formed = well_formed && (req.size == 32'h0);
        else
            well_formed = 1'b0;
    end

    mfb_bus_engine #(
        .ADDR_W  (ADDR_W),
        .TIMEOUT (TIMEOUT)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .write     (req.op == OP_WRITE),
        .two_words (req.size == 32'd8),
        .base_adr  ({req.addr[ADDR_W-1:2], 2'b00}),
        .sel       (lane_mask(req.size, req.addr[1:0])),
        .wdata     (place_write(req.size, req.addr[1:0], req.payload)),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_we     (wb_we),
        .wb_adr    (wb_adr),
        .wb_dat_w  (wb_dat_w),
        .wb_sel    (wb_sel),
        .wb_dat_r  (wb_dat_r),
        .wb_ack    (wb_ack),
        .done      (eng_done),
        .timed_out (eng_tmo),
        .rdata     (eng_rdata)
    );

    always_comb begin
        st_nxt      = st;
        rsp_load    = 1'b0;
        rsp_payload = '0;
        eng_start   = 1'b0;
        unique case (st)
            ST_COLLECT: if (rx_last) st_nxt = ST_DECODE;
            ST_DECODE: begin
                if (!well_formed) begin
                    rsp_load    = 1'b1;
                    rsp_payload = '1;
                    st_nxt      = ST_REPLY;
                end else if (is_poll) begin
                    rsp_load = 1'b1;
                    st_nxt   = ST_REPLY;
                end else begin
                    eng_start = 1'b1;
                    st_nxt    = ST_BUS;
                end
            end
            ST_BUS: begin
                if (eng_done) begin
                    rsp_load = 1'b1;
                    st_nxt   = ST_REPLY;
                    if (eng_tmo)
                        rsp_payload = '1;
                    else if (req.op == OP_READ)
                        rsp_payload = extract_read(req.size, req.addr[1:0], eng_rdata);
                end
            end
            ST_REPLY: if (tx_last) st_nxt = ST_COLLECT;
            default: st_nxt = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_COLLECT;
        else     st <= st_nxt;
    end

    mfb_tx_ser u_tx (
        .clk        (clk),
        .rst        (rst),
        .load       (rsp_load),
        .load_frame (pack_rsp(req.op, req.size, irq_vec, rsp_payload)),
        .out_ready  (rsp_ready),
        .out_valid  (rsp_valid),
        .out_data   (rsp_data),
        .last_beat  (tx_last)
    );
endmodule

// File: rtl/mfb_checker.sv
module mfb_checker #(
    parameter int unsigned TIMEOUT = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [7:0] rsp_data,
    input logic       wb_cyc,
    input logic       wb_stb,
    input logic [3:0] wb_sel,
    input logic       wb_ack
);
    localparam int unsigned STALL_W = $clog2(TIMEOUT + 1);

    logic [STALL_W-1:0] stall_cnt;

    always_ff @(posedge clk) begin
        if (rst)                   stall_cnt <= '0;
        else if (wb_stb && !wb_ack) stall_cnt <= stall_cnt + 1'b1;
        else                        stall_cnt <= '0;
    end

    AST_HOLD_OFF_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R10

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        wb_cyc |-> (!req_ready && !rsp_valid)); // R10

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R12

    AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (rst)
        wb_stb |-> wb_cyc); // R5

    AST_LANES_PRESENT: assert property (@(posedge clk) disable iff (rst)
        wb_stb |-> (wb_sel != 4'b0000)); // R5

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (wb_stb && !wb_ack) |-> (stall_cnt < STALL_W'(TIMEOUT))); // R9
endmodule

bind mmio_frame_bridge mfb_checker #(.TIMEOUT(TIMEOUT)) u_mfb_checker (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_sel    (wb_sel),
    .wb_ack    (wb_ack)
);

// File: tb/mmio_frame_bridge_bench.sv
module mmio_frame_bridge_bench;

    localparam logic [31:0] MAGIC_Q = 32'h3051_584C;
    localparam logic [31:0] MAGIC_A = 32'h3052_584C;
    localparam logic [31:0] IRQ_A   = 32'h8000_0105;

    typedef struct packed {
        logic [15:0] op;
        logic [31:0] size;
        logic [31:0] addr;
        logic [63:0] wdata;
        logic [63:0] exp;
        logic [3:0]  acks;
        logic [3:0]  sel;
        logic [31:0] last_adr;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{16'd1, 32'd4, 32'h10, 64'h1122_3344,          64'h0,                  4'd1, 4'b1111, 32'h10},
        '{16'd0, 32'd4, 32'h10, 64'h0,                  64'h1122_3344,          4'd1, 4'b1111, 32'h10},
        '{16'd1, 32'd1, 32'h12, 64'hAB,                 64'h0,                  4'd1, 4'b0100, 32'h10},
        '{16'd0, 32'd1, 32'h13, 64'h0,                  64'h11,                 4'd1, 4'b1000, 32'h10},
        '{16'd0, 32'd2, 32'h12, 64'h0,                  64'h11AB,               4'd1, 4'b1100, 32'h10},
        '{16'd1, 32'd8, 32'h20, 64'hCAFE_F00D_1234_5678, 64'h0,                 4'd2, 4'b1111, 32'h24},
        '{16'd0, 32'd8, 32'h20, 64'h0,                  64'hCAFE_F00D_1234_5678, 4'd2, 4'b1111, 32'h24},
        '{16'd2, 32'd0, 32'h0,  64'h0,                  64'h0,                  4'd0, 4'b0000, 32'h0},
        '{16'd1, 32'd2, 32'h16, 64'hBEEF,               64'h0,                  4'd1, 4'b1100, 32'h14},
        '{16'd0, 32'd4, 32'h14, 64'h0,                  64'hBEEF_0000,          4'd1, 4'b1111, 32'h14},
        '{16'd0, 32'd1, 32'h20, 64'h0,                  64'h78,                 4'd1, 4'b0001, 32'h20}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_data = 8'h00;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] irq_vec = IRQ_A;
    logic        wb_cyc, wb_stb, wb_we;
    logic [31:0] wb_adr, wb_dat_w;
    logic [3:0]  wb_sel;
    logic [31:0] wb_dat_r;
    logic        wb_ack;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    mmio_frame_bridge u_mmio_frame_bridge (
        .clk(clk), .rst(rst),
        .req_data(req_data), .req_valid(req_valid), .req_ready(req_ready),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .irq_vec(irq_vec),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
    );

    // Bus slave model: 16 words, one wait state, never answers above 0xF0000000.
    logic [31:0] mem [0:15];
    int          n_acks = 0;
    int          n_stb  = 0;
    logic [3:0]  seen_sel = '0;
    logic [31:0] seen_adr = '0;
    logic        seen_we  = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_ack   <= 1'b0;
            wb_dat_r <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            wb_ack <= 1'b0;
            if (wb_stb) n_stb <= n_stb + 1;
            if (wb_stb && wb_ack) begin
                n_acks   <= n_acks + 1;
                seen_sel <= wb_sel;
                seen_adr <= wb_adr;
                seen_we  <= wb_we;
            end
            if (wb_stb && !wb_ack && wb_adr[31:28] != 4'hF) begin
                wb_ack   <= 1'b1;
                wb_dat_r <= mem[wb_adr[5:2]];
                if (wb_we)
                    for (int b = 0; b < 4; b++)
                        if (wb_sel[b]) mem[wb_adr[5:2]][8*b +: 8] <= wb_dat_w[8*b +: 8];
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [255:0] f);
        for (int i = 0; i < 32; i++) begin
            req_valid = 1'b1;
            req_data  = f[8*i +: 8];
            while (!req_ready) @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic recv_frame(output logic [255:0] f);
        f = '0;
        rsp_ready = 1'b1;
        for (int i = 0; i < 32; i++) begin
            while (!rsp_valid) @(negedge clk);
            f[8*i +: 8] = rsp_data;
            @(negedge clk);
        end
        rsp_ready = 1'b0;
    endtask

    function automatic logic [255:0] mk_req(input logic [31:0] magic, input logic [15:0] ver,
                                            input logic [15:0] op, input logic [31:0] size,
                                            input logic [63:0] addr, input logic [63:0] wd);
        return {wd, addr, 32'h0, size, op, ver, magic};
    endfunction

    task automatic txn(input logic [255:0] q, output logic [255:0] a,
                       output int dacks, output int dstb);
        int a0, s0;
        a0 = n_acks;
        s0 = n_stb;
        send_frame(q);
        recv_frame(a);
        dacks = n_acks - a0;
        dstb  = n_stb - s0;
    endtask

    task automatic chk_header(input string tag, input logic [255:0] a,
                              input logic [15:0] op, input logic [31:0] size,
                              input logic [31:0] irq);
        chk({tag, " R2 magic"},   a[31:0],    MAGIC_A);
        chk({tag, " R2 version"}, a[47:32],   16'd1);
        chk({tag, " R2 op echo"}, a[63:48],   op);
        chk({tag, " R2 size"},    a[95:64],   size);
        chk({tag, " R2 irq"},     a[127:96],  irq);
        chk({tag, " R2 zeros"},   a[191:128], 64'h0);
    endtask

    // Malformed request: no strobe at all, data all ones.
    task automatic bad_case(input string tag, input logic [255:0] q);
        logic [255:0] a;
        int da, ds;
        txn(q, a, da, ds);
        chk({tag, " R8 data"}, a[255:192], '1);
        chk({tag, " R8 no bus"}, 64'(ds), 64'd0);
    endtask

    initial begin
        logic [255:0] a;
        logic [7:0]   held;
        int           da, ds;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R11 req_ready", 64'(req_ready), 64'd1);
        chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11 wb_cyc",    64'(wb_cyc),    64'd0);

        // Table walk: R1 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            string t;
            t = $sformatf("vec%0d", v);
            txn(mk_req(MAGIC_Q, 16'd1, VECS[v].op, VECS[v].size, 64'(VECS[v].addr),
                       VECS[v].wdata), a, da, ds);
            chk_header(t, a, VECS[v].op, VECS[v].size, IRQ_A);
            chk({t, " R3 R4 data"},  a[255:192], VECS[v].exp);
            chk({t, " R6 R7 acks"},  64'(da), 64'(VECS[v].acks));
            if (VECS[v].acks != 0) begin
                chk({t, " R5 sel"},     64'(seen_sel), 64'(VECS[v].sel));
                chk({t, " R5 R6 adr"},  64'(seen_adr), 64'(VECS[v].last_adr));
                chk({t, " R4 we"},      64'(seen_we),  64'(VECS[v].op == 16'd1));
            end
        end

        // R7: poll reflects a changed interrupt vector
        irq_vec = 32'h0000_7F00;
        txn(mk_req(MAGIC_Q, 16'd1, 16'd2, 32'd0, 64'h0, 64'h0), a, da, ds);
        chk("R7 poll irq", a[127:96], 32'h0000_7F00);
        chk("R7 poll no bus", 64'(ds), 64'd0);
        irq_vec = IRQ_A;

        // R8: malformed requests
        bad_case("magic",   mk_req(32'h1234_5678, 16'd1, 16'd0, 32'd4, 64'h10, 64'h0));
        bad_case("version", mk_req(MAGIC_Q, 16'd2, 16'd0, 32'd4, 64'h10, 64'h0));
        bad_case("op3",     mk_req(MAGIC_Q, 16'd1, 16'd3, 32'd4, 64'h10, 64'h0));
        bad_case("size3",   mk_req(MAGIC_Q, 16'd1, 16'd1, 32'd3, 64'h10, 64'h55));
        bad_case("pollsz",  mk_req(MAGIC_Q, 16'd1, 16'd2, 32'd4, 64'h0, 64'h0));
        bad_case("wideadr", mk_req(MAGIC_Q, 16'd1, 16'd0, 32'd4, 64'h1_0000_0010, 64'h0));
        // the rejected write of size 3 must not have touched memory
        txn(mk_req(MAGIC_Q, 16'd1, 16'd0, 32'd4, 64'h10, 64'h0), a, da, ds);
        chk("R8 mem untouched", a[255:192], 64'h11AB_3344);

        // R9: dead slave
        txn(mk_req(MAGIC_Q, 16'd1, 16'd0, 32'd4, 64'hF000_0000, 64'h0), a, da, ds);
        chk("R9 timeout data", a[255:192], '1);
        chk("R9 strobe cycles", 64'(ds), 64'd256);
        chk("R9 no ack", 64'(da), 64'd0);
        txn(mk_req(MAGIC_Q, 16'd1, 16'd0, 32'd4, 64'h24, 64'h0), a, da, ds);
        chk("R9 recovery read", a[255:192], 64'hCAFE_F00D);

        // R10 R12: stall the response while the next request is offered
        send_frame(mk_req(MAGIC_Q, 16'd1, 16'd0, 32'd4, 64'h14, 64'h0));
        req_valid = 1'b1;
        req_data  = 8'h4C;
        while (!rsp_valid) @(negedge clk);
        held = rsp_data;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            chk("R10 ready held low", 64'(req_ready), 64'd0);
            chk("R12 byte stable", 64'({rsp_valid, rsp_data}), 64'({1'b1, held}));
        end
        req_valid = 1'b0;
        recv_frame(a);
        chk("R10 stalled data", a[255:192], 64'hBEEF_0000);
        chk("R10 ready after", 64'(req_ready), 64'd1);
        txn(mk_req(MAGIC_Q, 16'd1, 16'd0, 32'd1, 64'h13, 64'h0), a, da, ds);
        chk("R1 next frame", a[255:192], 64'h11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule